// File: doc/BRIEF.md
# Path Parity and Remote Error Indication Inserter

This block sits on the transmit side of a path overhead generator, in front of the scrambler. It sees the unscrambled outgoing path frame one byte at a time, with a strobe that marks the first byte of each frame and strobes that mark the two overhead slots it owns: the path parity byte and the status byte. For each frame it keeps an even bit-interleaved parity over all eight bit lanes of every byte it emits. The finished value of one frame is written into the parity slot of the next frame. Every other byte passes through unchanged, one cycle later.

The status slot keeps its low four bits. Its high four bits carry a remote error indication. By default this is the receive-side block error count, supplied from outside and clamped to eight. A register value can stand in for the count through an inhibit bit. A fixed error code of 3 can be forced while a trigger is active and both the forcing bit and a global insert enable are set.

The same trigger drives parity error injection. When injection is enabled, each rising edge of the trigger inverts exactly one parity byte, however long the trigger stays high.

Top module: `path_bip_rei`

## Requirements
- R1: The byte in the parity slot (`in_b3_slot`) equals the XOR of every byte emitted between the previous `in_sof` byte and the byte before the current frame's `in_sof`, both ends included. The parity slot never falls on an `in_sof` byte.
- R2: The first frame after reset carries 0x00 in its parity slot.
- R3: `out_valid` follows `in_valid` one cycle later. A valid byte that is in neither slot appears unchanged on `out_data` one cycle later.
- R4: Cycles with `in_valid` low add nothing to the parity and give `out_valid` low.
- R5: With `errins_en` high, a rising edge of `err_trig` inverts all bits of one parity byte: the next one, or the one in the same cycle if the edge falls on the parity slot. Holding `err_trig` high corrupts no further byte. The inverted byte counts toward the next frame's parity.
- R6: With `errins_en` low, a rising edge of `err_trig` leaves the parity bytes intact, and an injection that is armed but not yet done is dropped.
- R7: In the status slot (`in_g1_slot`), bits 3:0 pass through. Bits 7:4 carry `rx_b3_err_cnt`, with any value above 8 sent as 8.
- R8: With `rei_inhibit` high, status bits 7:4 carry `rei_value` instead of the count.
- R9: When `rei_force`, `err_trig` and `glob_errins_en` are all high, status bits 7:4 carry 0x3. This takes precedence over R8 and R7.
- R10: During reset `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_data | input | 8 | Unscrambled outgoing byte |
| in_sof | input | 1 | First byte of a path frame |
| in_b3_slot | input | 1 | This byte is the path parity slot |
| in_g1_slot | input | 1 | This byte is the path status slot |
| rx_b3_err_cnt | input | 4 | Receive-side parity block error count |
| errins_en | input | 1 | Enables parity error injection |
| err_trig | input | 1 | Error-insert trigger |
| glob_errins_en | input | 1 | Global error-insert enable |
| rei_inhibit | input | 1 | Replace the count with `rei_value` |
| rei_value | input | 4 | Register value for status bits 7:4 |
| rei_force | input | 1 | Continuous error forcing on status bits 7:4 |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Byte with overhead inserted |

## Verification
Parity injection and the parity slot can fall in the same cycle when the trigger's rising edge lands on the parity byte itself. In that case the byte must be inverted at once, and it must not be inverted a second time in the next frame. The bench raises the trigger in exactly that cycle and compares the byte against its own frame model. It also compares the following frame's parity, which has to include the inverted byte. A trigger held high across several frames, and a trigger left high during the status-byte table, check that the level-sensitive REI forcing never re-arms the edge-sensitive injection.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
   typedef enum logic [1:0] {
      SLOT_DATA = 2'd0,
      SLOT_PAR  = 2'd1,
      SLOT_STAT = 2'd2
   } slot_e;

   function automatic slot_e slot_of(input logic par, input logic stat);
      if (par)       return SLOT_PAR;
      else if (stat) return SLOT_STAT;
      else           return SLOT_DATA;
   endfunction
endpackage

// File: rtl/pbr_bip_acc.sv
module pbr_bip_acc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid,
   input  logic         sof,
   input  logic [W-1:0] byte_in,
   output logic [W-1:0] par_prev
);
   logic [W-1:0] acc_q;
   logic [W-1:0] done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         done_q <= '0;
      end else if (valid) begin
         if (sof) begin
            done_q <= acc_q;
            acc_q  <= byte_in;
         end else begin
            acc_q  <= acc_q ^ byte_in;
         end
      end
   end

   assign par_prev = done_q;
endmodule

// File: rtl/pbr_inj_arm.sv
module pbr_inj_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic trig,
   input  logic strike,
   output logic fire
);
   logic trig_q;
   logic pend_q;
   logic rise;

   assign rise = trig & ~trig_q;
   assign fire = strike & en & (pend_q | rise);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         trig_q <= trig;
         pend_q <= (pend_q | rise) & en & ~fire;
      end
   end
endmodule

// File: rtl/pbr_rei_sel.sv
module pbr_rei_sel #(
   parameter int REI_W      = 4,
   parameter int REI_MAX    = 8,
   parameter int FORCE_CODE = 3
) (
   input  logic [REI_W-1:0] cnt,
   input  logic             inhibit,
   input  logic [REI_W-1:0] reg_val,
   input  logic             force_act,
   output logic [REI_W-1:0] rei
);
   localparam logic [REI_W-1:0] MAX_V   = REI_W'(REI_MAX);
   localparam logic [REI_W-1:0] FORCE_V = REI_W'(FORCE_CODE);

   logic [REI_W-1:0] clamped;

   assign clamped = (cnt > MAX_V) ? MAX_V : cnt;

   always_comb begin
      if (force_act)    rei = FORCE_V;
      else if (inhibit) rei = reg_val;
      else              rei = clamped;
   end
endmodule

// File: rtl/path_bip_rei.sv
module path_bip_rei #(
   parameter int W          = 8,
   parameter int REI_W      = 4,
   parameter int REI_MAX    = 8,
   parameter int FORCE_CODE = 3,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [W-1:0]     in_data,
   input  logic             in_sof,
   input  logic             in_b3_slot,
   input  logic             in_g1_slot,
   input  logic [REI_W-1:0] rx_b3_err_cnt,
   input  logic             errins_en,
   input  logic             err_trig,
   input  logic             glob_errins_en,
   input  logic             rei_inhibit,
   input  logic [REI_W-1:0] rei_value,
   input  logic             rei_force,
   output logic             out_valid,
   output logic [W-1:0]     out_data
);
   import pbr_pkg::*;

   localparam int LOW_W = W - REI_W;

   if (REI_W >= W) begin : g_bad_width
      $error("REI field must be narrower than the byte");
   end
   if (REI_MAX >= (1 << REI_W)) begin : g_bad_max
      $error("REI clamp does not fit in the field");
   end
   if (FORCE_CODE >= (1 << REI_W)) begin : g_bad_force
      $error("forced REI code does not fit in the field");
   end

   slot_e            kind;
   logic [W-1:0]     par_prev;
   logic             fire;
   logic [REI_W-1:0] rei;
   logic [W-1:0]     out_byte;
   logic             force_act;

   assign kind      = slot_of(in_b3_slot, in_g1_slot);
   assign force_act = rei_force & err_trig & glob_errins_en;

   pbr_inj_arm u_arm (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (errins_en),
      .trig   (err_trig),
      .strike (in_valid & (kind == SLOT_PAR)),
      .fire   (fire)
   );

   pbr_rei_sel #(
      .REI_W      (REI_W),
      .REI_MAX    (REI_MAX),
      .FORCE_CODE (FORCE_CODE)
   ) u_rei (
      .cnt       (rx_b3_err_cnt),
      .inhibit   (rei_inhibit),
      .reg_val   (rei_value),
      .force_act (force_act),
      .rei       (rei)
   );

   always_comb begin
      unique case (kind)
         SLOT_PAR:  out_byte = par_prev ^ {W{fire}};
         SLOT_STAT: out_byte = {rei, in_data[LOW_W-1:0]};
         default:   out_byte = in_data;
      endcase
   end

   pbr_bip_acc #(.W(W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (in_valid),
      .sof      (in_sof),
      .byte_in  (out_byte),
      .par_prev (par_prev)
   );

   if (OUT_REG) begin : g_reg_out
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else begin
            v_q <= in_valid;
            if (in_valid) d_q <= out_byte;
         end
      end
      assign out_valid = v_q;
      assign out_data  = d_q;
   end else begin : g_comb_out
      assign out_valid = in_valid;
      assign out_data  = in_valid ? out_byte : '0;
   end
endmodule

// File: rtl/pbr_chk.sv
module pbr_chk #(
   parameter int W       = 8,
   parameter int REI_W   = 4,
   parameter int REI_MAX = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [W-1:0]     in_data,
   input logic             in_b3_slot,
   input logic             in_g1_slot,
   input logic [REI_W-1:0] rx_b3_err_cnt,
   input logic             err_trig,
   input logic             glob_errins_en,
   input logic             rei_inhibit,
   input logic [REI_W-1:0] rei_value,
   input logic             rei_force,
   input logic             out_valid,
   input logic [W-1:0]     out_data
);
   localparam int LOW_W = W - REI_W;
   logic frc;
   assign frc = rei_force & err_trig & glob_errins_en;

   if (OUT_REG) begin : g_props
      assert_valid_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_idle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !in_b3_slot && !in_g1_slot) |=> out_data == $past(in_data));
      assert_stat_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_g1_slot && !in_b3_slot)
            |=> out_data[LOW_W-1:0] == $past(in_data[LOW_W-1:0]));
      assert_rei_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_g1_slot && !in_b3_slot && !frc && !rei_inhibit)
            |=> out_data[W-1:LOW_W] == (($past(rx_b3_err_cnt) > REI_W'(REI_MAX))
                                        ? REI_W'(REI_MAX) : $past(rx_b3_err_cnt)));
      assert_rei_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_g1_slot && !in_b3_slot && !frc && rei_inhibit)
            |=> out_data[W-1:LOW_W] == $past(rei_value));
      assert_rei_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_g1_slot && !in_b3_slot && frc)
            |=> out_data[W-1:LOW_W] == REI_W'(3));
   end
endmodule

bind path_bip_rei pbr_chk #(
   .W       (W),
   .REI_W   (REI_W),
   .REI_MAX (REI_MAX),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .in_data        (in_data),
   .in_b3_slot     (in_b3_slot),
   .in_g1_slot     (in_g1_slot),
   .rx_b3_err_cnt  (rx_b3_err_cnt),
   .err_trig       (err_trig),
   .glob_errins_en (glob_errins_en),
   .rei_inhibit    (rei_inhibit),
   .rei_value      (rei_value),
   .rei_force      (rei_force),
   .out_valid      (out_valid),
   .out_data       (out_data)
);

// File: tb/sim_path_bip_rei.sv
`timescale 1ns/100ps
module sim_path_bip_rei;
   localparam int FL = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_sof = 1'b0, in_b3_slot = 1'b0, in_g1_slot = 1'b0;
   logic [3:0] rx_b3_err_cnt = '0;
   logic       errins_en = 1'b0, err_trig = 1'b0, glob_errins_en = 1'b0;
   logic       rei_inhibit = 1'b0, rei_force = 1'b0;
   logic [3:0] rei_value = '0;
   logic       out_valid;
   logic [7:0] out_data;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] m_acc = '0, m_prev = '0;
   logic       m_pend = 1'b0, m_trig_q = 1'b0;
   logic       trig_lvl = 1'b0;

   always #2.5 clk = ~clk;

   path_bip_rei u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sof(in_sof), .in_b3_slot(in_b3_slot), .in_g1_slot(in_g1_slot),
      .rx_b3_err_cnt(rx_b3_err_cnt), .errins_en(errins_en), .err_trig(err_trig),
      .glob_errins_en(glob_errins_en), .rei_inhibit(rei_inhibit),
      .rei_value(rei_value), .rei_force(rei_force),
      .out_valid(out_valid), .out_data(out_data)
   );

   // vector: inhibit, force, trig, glob, count, reg value, expected bits 7:4
   localparam int NV = 8;
   localparam logic [15:0] VEC [NV] = '{
      {4'b0000, 4'd5,  4'd0, 4'd5},   // R7 plain count
      {4'b0000, 4'd8,  4'd0, 4'd8},   // R7 upper bound
      {4'b0000, 4'd12, 4'd0, 4'd8},   // R7 clamp
      {4'b0000, 4'd15, 4'd3, 4'd8},   // R7 clamp at max code
      {4'b1000, 4'd2,  4'd10, 4'd10}, // R8 inhibit
      {4'b1111, 4'd6,  4'd9, 4'd3},   // R9 force over inhibit
      {4'b0110, 4'd2,  4'd0, 4'd2},   // R9 global enable low
      {4'b1101, 4'd1,  4'd6, 4'd6}    // R9 trigger low
   };

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   function automatic logic [3:0] rei_model();
      if (rei_force && err_trig && glob_errins_en) return 4'd3;
      if (rei_inhibit) return rei_value;
      return (rx_b3_err_cnt > 4'd8) ? 4'd8 : rx_b3_err_cnt;
   endfunction

   // called just after a falling edge; result sampled at the next one
   task automatic put(input logic v, input logic [7:0] d, input logic sof,
                      input logic b3, input logic g1, input string tag);
      logic rise, fire;
      logic [7:0] exp;
      in_valid = v; in_data = d; in_sof = sof; in_b3_slot = b3; in_g1_slot = g1;
      err_trig = trig_lvl;
      rise = err_trig & ~m_trig_q;
      fire = v & b3 & errins_en & (m_pend | rise);
      m_pend = (m_pend | rise) & errins_en & ~fire;
      m_trig_q = err_trig;
      if (b3)      exp = m_prev ^ {8{fire}};
      else if (g1) exp = {rei_model(), d[3:0]};
      else         exp = d;
      if (v) begin
         if (sof) begin m_prev = m_acc; m_acc = exp; end
         else m_acc = m_acc ^ exp;
      end
      @(negedge clk);
      check({tag, " valid"}, {7'd0, out_valid}, {7'd0, v});
      if (v) check(tag, out_data, exp);
   endtask

   task automatic send_frame(input logic [7:0] seed, input int trig_at,
                             input bit gap, input string tag);
      for (int i = 0; i < FL; i++) begin
         if (i == trig_at) trig_lvl = 1'b1;
         if (gap && i == 6) put(1'b0, 8'hA5 ^ seed, 1'b0, 1'b0, 1'b0, "R4 idle");
         put(1'b1, seed ^ 8'(i * 29 + 7), i == 0, i == 2, i == 4, tag);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset valid", {7'd0, out_valid}, 8'd0);
      check("R10 reset data", out_data, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rx_b3_err_cnt = 4'd4;

      send_frame(8'h3C, -1, 1'b0, "R2 first frame");
      send_frame(8'hF0, -1, 1'b0, "R1 parity");
      send_frame(8'h5A, -1, 1'b1, "R1 R4 gap");
      send_frame(8'h81, -1, 1'b0, "R1 after gap");

      // REI table, injection disabled so trigger levels only matter to R9
      for (int k = 0; k < NV; k++) begin
         rei_inhibit    = VEC[k][15];
         rei_force      = VEC[k][14];
         trig_lvl       = VEC[k][13];
         glob_errins_en = VEC[k][12];
         rx_b3_err_cnt  = VEC[k][11:8];
         rei_value      = VEC[k][7:4];
         send_frame(8'(k * 17 + 1), -1, 1'b0, "R7 R8 R9 table");
         check("R7 R8 R9 table model", {4'd0, rei_model()}, {4'd0, VEC[k][3:0]});
      end
      rei_inhibit = 1'b0; rei_force = 1'b0; glob_errins_en = 1'b0;
      rx_b3_err_cnt = 4'd1; trig_lvl = 1'b0;

      // R5: edge before the slot, then held high for two more frames
      errins_en = 1'b1;
      send_frame(8'h11, 0, 1'b0, "R5 edge before slot");
      send_frame(8'h22, -1, 1'b0, "R5 held high");
      send_frame(8'h33, -1, 1'b0, "R5 held high");
      trig_lvl = 1'b0;
      send_frame(8'h44, -1, 1'b0, "R5 release");
      // R5: edge lands on the parity slot cycle itself
      send_frame(8'h55, 2, 1'b0, "R5 edge on slot");
      trig_lvl = 1'b0;
      send_frame(8'h66, -1, 1'b0, "R5 follow-up parity");

      // R6: injection disabled
      errins_en = 1'b0;
      send_frame(8'h77, 0, 1'b0, "R6 disabled");
      trig_lvl = 1'b0;
      send_frame(8'h88, -1, 1'b0, "R6 disabled");
      // R6: arm, then drop enable before the slot
      errins_en = 1'b1;
      trig_lvl = 1'b1;
      put(1'b1, 8'h9C, 1'b1, 1'b0, 1'b0, "R6 arm");
      errins_en = 1'b0;
      for (int i = 1; i < FL; i++)
         put(1'b1, 8'(i * 13), 1'b0, i == 2, i == 4, "R6 armed then disabled");
      errins_en = 1'b1;
      send_frame(8'hAB, -1, 1'b0, "R6 no late injection");
      put(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R4 idle end");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule